// File: doc/BRIEF.md
# Interrupt Cause and Status Register Unit with Deferred Completion

This block holds the interrupt-cause register, the status register, the sequence-step register and the first configuration register of a command-driven bus controller, and it drives the interrupt line. Events from the rest of the controller set cause bits and raise the interrupt: a command-complete report, a bus-reset command and a terminal-count indication. When the host reads the interrupt-cause register, it receives the current causes, and the same read clears them.

Only one interrupt is presented at a time. If a command completes while an interrupt is still pending, the completion's status byte is parked in a single deferral slot. The host read that acknowledges the pending interrupt then posts the parked completion, so the interrupt line stays high for the new cause.

The control is a three-state machine. IDLE means no interrupt is pending. PEND means an interrupt is pending and the slot is empty. PEND_DEF means an interrupt is pending and a completion is parked. The transitions are:
- IDLE to PEND on a completion, or on a bus reset whose reporting is enabled.
- PEND to IDLE on an acknowledging read with no new event in the same cycle.
- PEND to PEND_DEF on a completion that arrives without a read.
- PEND_DEF to PEND on a read, which posts the parked completion.
- PEND_DEF stays in PEND_DEF on a read that arrives in the same cycle as a new completion. The read posts the old completion and parks the new one.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the interrupt line is low. The cause, status and sequence registers are 0x00. The configuration register reads 0x07. The captured status byte is 0x00.
- R2: A completion arriving with no interrupt pending is reported at the next clock edge:
  - status becomes phase code 3 (bits 2:0) plus terminal-count (bit 4, 0x10) plus pending (bit 7, 0x80), which is 0x93;
  - cause becomes bus-service 0x10;
  - sequence step becomes 0;
  - the completion's status byte is captured;
  - the interrupt line goes high.
- R3: `rd_data_o` shows the cause register before the read. At the next edge the read performs its clear:
  - cause becomes 0;
  - status bits 7 and 4 are cleared, while the phase bits 2:0 are kept;
  - sequence step becomes the done code 4;
  - the interrupt line goes low.
- R4: A completion that arrives while an interrupt is pending and no read occurs leaves the cause, status, sequence and line unchanged. Its status byte is parked.
- R5: A read while a completion is parked posts that completion at the same edge, with the values of R2 and the parked status byte. The interrupt line stays high and the slot empties.
- R6: The slot holds one completion. A further completion that arrives while the slot is full and no read occurs is discarded.
- R7: A bus-reset strobe sets cause bit 7 (0x80), ORed with any cause set in the same cycle. It raises the interrupt only when configuration bit 6 is clear.
- R8: When a read and a new event fall in the same cycle, the event wins over the clear:
  - a completion is reported;
  - a bus reset sets its cause and raises the line;
  - a terminal-count strobe leaves status bit 4 set.
- R9: A terminal-count strobe sets status bit 4 at the next edge.
- R10: The interrupt line always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_intr_i | input | 1 | Host read of the cause register (one-cycle strobe) |
| cmplt_i | input | 1 | Command-complete event |
| cmplt_status_i | input | 8 | Status byte of the completion |
| busrst_i | input | 1 | Bus-reset command strobe |
| tc_i | input | 1 | Terminal-count reached strobe |
| cfg1_we_i | input | 1 | Configuration register write enable |
| cfg1_wdata_i | input | 8 | Configuration register write data |
| irq_o | output | 1 | Registered interrupt line |
| rd_data_o | output | 8 | Cause register value returned to a read |
| intr_o | output | 8 | Cause register |
| stat_o | output | 8 | Status register |
| seq_o | output | 3 | Sequence-step register |
| cfg1_o | output | 8 | Configuration register |
| cmplt_status_o | output | 8 | Status byte of the last reported completion |

## Verification
The completion path is tried in three situations: with the line idle, with an interrupt pending, and with the slot already full. This separates an immediate report from parking and from discarding. Reads are issued alone, while a completion is parked, and in the same cycle as a completion, a bus reset or a terminal-count strobe. This shows whether the clear or the event wins, and whether the parked byte or the new byte is posted. Bus resets are issued with the report-disable bit both clear and set, and together with a completion, which checks the gating and the OR into the cause register.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int DATA_W       = 8;
    localparam int SEQ_W        = 3;
    localparam logic [DATA_W-1:0] CFG1_RST = 8'h07;
    localparam int STAT_PEND_B  = 7;
    localparam int STAT_TC_B    = 4;
    localparam int PHASE_W      = 3;
    localparam logic [PHASE_W-1:0] PHASE_STATUS = 3'd3;
    localparam logic [DATA_W-1:0] CAUSE_BUS_SVC = 8'h10;
    localparam logic [DATA_W-1:0] CAUSE_BUS_RST = 8'h80;
    localparam logic [SEQ_W-1:0]  SEQ_DONE = 3'd4;
    localparam int CFG1_RPTDIS_B = 6;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PEND     = 2'd1,
        ST_PEND_DEF = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic cmplt_i,
    input  logic busrst_i,
    input  logic rpt_dis_i,
    output logic rep_new_o,
    output logic rep_def_o,
    output logic defer_ld_o,
    output logic int_next_o,
    output logic slot_full_o,
    output logic irq_o
);
    irq_state_e state_q, state_n;
    logic int_q, int_after_rd, slot_free, def_next;

    always_comb begin
        int_q        = (state_q != ST_IDLE);
        slot_full_o  = (state_q == ST_PEND_DEF);
        int_after_rd = int_q & ~rd_i;
        rep_def_o    = rd_i & slot_full_o;
        rep_new_o    = cmplt_i & ~int_after_rd & ~rep_def_o;
        slot_free    = ~(slot_full_o & ~rd_i);
        defer_ld_o   = cmplt_i & ~rep_new_o & slot_free;
        int_next_o   = int_after_rd | rep_def_o | rep_new_o
                     | (busrst_i & ~rpt_dis_i);
        def_next     = (slot_full_o & ~rd_i) | defer_ld_o;
        unique case (1'b1)
            !int_next_o: state_n = ST_IDLE;
            def_next:    state_n = ST_PEND_DEF;
            default:     state_n = ST_PEND;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= int_next_o;
    end
endmodule

// File: rtl/irq_defer_slot.sv
module irq_defer_slot
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] status_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      status_o <= '0;
        else if (load_i) status_o <= status_i;
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              report_i,
    input  logic [DATA_W-1:0] report_status_i,
    input  logic              busrst_i,
    input  logic              tc_i,
    input  logic              int_next_i,
    input  logic              cfg1_we_i,
    input  logic [DATA_W-1:0] cfg1_wdata_i,
    output logic [DATA_W-1:0] intr_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cst_o
);
    logic [DATA_W-1:0] intr_n, stat_n, cst_n;
    logic [SEQ_W-1:0]  seq_n;

    always_comb begin
        intr_n = intr_o;
        stat_n = stat_o;
        seq_n  = seq_o;
        cst_n  = cst_o;
        if (rd_i) begin
            intr_n = '0;
            stat_n[STAT_TC_B] = 1'b0;
            seq_n  = SEQ_DONE;
        end
        if (report_i) begin
            stat_n[PHASE_W-1:0] = PHASE_STATUS;
            stat_n[STAT_TC_B]   = 1'b1;
            intr_n = CAUSE_BUS_SVC;
            seq_n  = '0;
            cst_n  = report_status_i;
        end
        if (busrst_i) intr_n = intr_n | CAUSE_BUS_RST;
        if (tc_i)     stat_n[STAT_TC_B] = 1'b1;
        stat_n[STAT_PEND_B] = int_next_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_o <= '0;
            stat_o <= '0;
            seq_o  <= '0;
            cst_o  <= '0;
            cfg1_o <= CFG1_RST;
        end else begin
            intr_o <= intr_n;
            stat_o <= stat_n;
            seq_o  <= seq_n;
            cst_o  <= cst_n;
            if (cfg1_we_i) cfg1_o <= cfg1_wdata_i;
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_intr_i,
    input  logic              cmplt_i,
    input  logic [DATA_W-1:0] cmplt_status_i,
    input  logic              busrst_i,
    input  logic              tc_i,
    input  logic              cfg1_we_i,
    input  logic [DATA_W-1:0] cfg1_wdata_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] intr_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cmplt_status_o
);
    logic rep_new, rep_def, defer_ld, int_next, deferred;
    logic [DATA_W-1:0] slot_status, report_status;

    irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_intr_i),
        .cmplt_i    (cmplt_i),
        .busrst_i   (busrst_i),
        .rpt_dis_i  (cfg1_o[CFG1_RPTDIS_B]),
        .rep_new_o  (rep_new),
        .rep_def_o  (rep_def),
        .defer_ld_o (defer_ld),
        .int_next_o (int_next),
        .slot_full_o(deferred),
        .irq_o      (irq_o)
    );

    irq_defer_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (defer_ld),
        .status_i(cmplt_status_i),
        .status_o(slot_status)
    );

    assign report_status = rep_def ? slot_status : cmplt_status_i;

    irq_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_i           (rd_intr_i),
        .report_i       (rep_new | rep_def),
        .report_status_i(report_status),
        .busrst_i       (busrst_i),
        .tc_i           (tc_i),
        .int_next_i     (int_next),
        .cfg1_we_i      (cfg1_we_i),
        .cfg1_wdata_i   (cfg1_wdata_i),
        .intr_o         (intr_o),
        .stat_o         (stat_o),
        .seq_o          (seq_o),
        .cfg1_o         (cfg1_o),
        .cst_o          (cmplt_status_o)
    );

    assign rd_data_o = intr_o;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd,
    input logic       cmplt,
    input logic       busrst,
    input logic       tc,
    input logic       slot_full,
    input logic       irq,
    input logic [7:0] intr,
    input logic [7:0] stat,
    input logic [2:0] seq,
    input logic [7:0] cfg1
);
    a_r10_irq_mirrors_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq == stat[7]);

    a_r2_report_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmplt && !irq && !rd && !busrst |=>
            irq && intr == 8'h10 && stat == 8'h93 && seq == 3'd0);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !cmplt && !busrst && !tc && !slot_full |=>
            !irq && intr == 8'h00 && seq == 3'd4 && !stat[4]);

    a_r4_defer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cmplt && irq && !rd && !busrst && !tc |=>
            irq && $stable(intr) && $stable(stat) && $stable(seq));

    a_r5_post_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        rd && slot_full && !busrst |=> irq && intr == 8'h10 && seq == 3'd0);

    a_r7_reset_gated: assert property (@(posedge clk) disable iff (!rst_n)
        busrst && cfg1[6] && !irq && !cmplt |=> !irq && intr[7]);
endmodule

bind irq_status_ctrl irq_status_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (rd_intr_i),
    .cmplt    (cmplt_i),
    .busrst   (busrst_i),
    .tc       (tc_i),
    .slot_full(deferred),
    .irq      (irq_o),
    .intr     (intr_o),
    .stat     (stat_o),
    .seq      (seq_o),
    .cfg1     (cfg1_o)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 0, cm = 0, br = 0, tc = 0, we = 0;
    logic [7:0] st = 0, wd = 0;
    logic irq;
    logic [7:0] rdd, intr, stat, cfg1, cst;
    logic [2:0] seq;
    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rd_intr_i(rd), .cmplt_i(cm),
        .cmplt_status_i(st), .busrst_i(br), .tc_i(tc),
        .cfg1_we_i(we), .cfg1_wdata_i(wd), .irq_o(irq), .rd_data_o(rdd),
        .intr_o(intr), .stat_o(stat), .seq_o(seq), .cfg1_o(cfg1),
        .cmplt_status_o(cst)
    );

    typedef struct packed {
        logic       rd;
        logic       cm;
        logic [7:0] st;
        logic       br;
        logic       tc;
        logic       we;
        logic [7:0] wd;
        logic [7:0] e_rd;
        logic       e_irq;
        logic [7:0] e_intr;
        logic [7:0] e_stat;
        logic [2:0] e_seq;
        logic [7:0] e_cfg;
        logic [7:0] e_cst;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{0,0,8'h00,0,1,0,8'h00, 8'h00, 0,8'h00,8'h10,3'd0,8'h07,8'h00, 4'd9},  // R9
        '{0,1,8'h02,0,0,0,8'h00, 8'h00, 1,8'h10,8'h93,3'd0,8'h07,8'h02, 4'd2},  // R2
        '{0,1,8'h08,0,0,0,8'h00, 8'h00, 1,8'h10,8'h93,3'd0,8'h07,8'h02, 4'd4},  // R4
        '{0,1,8'h18,0,0,0,8'h00, 8'h00, 1,8'h10,8'h93,3'd0,8'h07,8'h02, 4'd6},  // R6
        '{1,0,8'h00,0,0,0,8'h00, 8'h10, 1,8'h10,8'h93,3'd0,8'h07,8'h08, 4'd5},  // R5
        '{1,0,8'h00,0,0,0,8'h00, 8'h10, 0,8'h00,8'h03,3'd4,8'h07,8'h08, 4'd3},  // R3
        '{1,0,8'h00,0,0,0,8'h00, 8'h00, 0,8'h00,8'h03,3'd4,8'h07,8'h08, 4'd3},  // R3
        '{0,0,8'h00,1,0,0,8'h00, 8'h00, 1,8'h80,8'h83,3'd4,8'h07,8'h08, 4'd7},  // R7
        '{1,1,8'h22,0,0,0,8'h00, 8'h80, 1,8'h10,8'h93,3'd0,8'h07,8'h22, 4'd8},  // R8
        '{1,0,8'h00,0,0,0,8'h00, 8'h10, 0,8'h00,8'h03,3'd4,8'h07,8'h22, 4'd3},  // R3
        '{0,0,8'h00,0,0,1,8'h47, 8'h00, 0,8'h00,8'h03,3'd4,8'h47,8'h22, 4'd7},  // R7
        '{0,0,8'h00,1,0,0,8'h00, 8'h00, 0,8'h80,8'h03,3'd4,8'h47,8'h22, 4'd7},  // R7
        '{1,0,8'h00,0,0,0,8'h00, 8'h80, 0,8'h00,8'h03,3'd4,8'h47,8'h22, 4'd3},  // R3
        '{0,0,8'h00,0,0,1,8'h07, 8'h00, 0,8'h00,8'h03,3'd4,8'h07,8'h22, 4'd7},  // R7
        '{0,0,8'h00,1,1,0,8'h00, 8'h00, 1,8'h80,8'h93,3'd4,8'h07,8'h22, 4'd9},  // R9
        '{1,0,8'h00,0,1,0,8'h00, 8'h80, 0,8'h00,8'h13,3'd4,8'h07,8'h22, 4'd8}   // R8
    };

    task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic c, input logic [7:0] s,
                         input logic b, input logic t, input logic w, input logic [7:0] d);
        rd = r; cm = c; st = s; br = b; tc = t; we = w; wd = d;
    endtask

    task automatic chk_all(input int req, input logic ei, input logic [7:0] eintr,
                           input logic [7:0] est, input logic [2:0] esq,
                           input logic [7:0] ecf, input logic [7:0] ecs);
        chk("irq", req, {7'd0, irq}, {7'd0, ei});
        chk("intr", req, intr, eintr);
        chk("stat", req, stat, est);
        chk("seq", req, {5'd0, seq}, {5'd0, esq});
        chk("cfg1", req, cfg1, ecf);
        chk("cst", req, cst, ecs);
        chk("irq=stat7 (R10)", 10, {7'd0, irq}, {7'd0, stat[7]});
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_all(1, 0, 8'h00, 8'h00, 3'd0, 8'h07, 8'h00);  // R1 reset state
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].rd, TBL[i].cm, TBL[i].st, TBL[i].br, TBL[i].tc, TBL[i].we, TBL[i].wd);
            #1;
            if (TBL[i].rd) chk("read data", int'(TBL[i].req), rdd, TBL[i].e_rd);
            @(negedge clk);
            chk_all(int'(TBL[i].req), TBL[i].e_irq, TBL[i].e_intr, TBL[i].e_stat,
                    TBL[i].e_seq, TBL[i].e_cfg, TBL[i].e_cst);
        end
        // R7: completion and bus reset together from idle
        drive(0, 1, 8'h33, 1, 0, 0, 8'h00);
        @(negedge clk);
        chk_all(7, 1, 8'h90, 8'h93, 3'd0, 8'h07, 8'h33);
        // R4: park 0x44
        drive(0, 1, 8'h44, 0, 0, 0, 8'h00);
        @(negedge clk);
        chk_all(4, 1, 8'h90, 8'h93, 3'd0, 8'h07, 8'h33);
        // R5/R8: read posts 0x44 while new 0x55 is parked
        drive(1, 1, 8'h55, 0, 0, 0, 8'h00);
        #1 chk("read data", 5, rdd, 8'h90);
        @(negedge clk);
        chk_all(5, 1, 8'h10, 8'h93, 3'd0, 8'h07, 8'h44);
        drive(1, 0, 8'h00, 0, 0, 0, 8'h00);
        @(negedge clk);
        chk_all(5, 1, 8'h10, 8'h93, 3'd0, 8'h07, 8'h55);
        // R3: final acknowledge
        @(negedge clk);
        chk_all(3, 0, 8'h00, 8'h03, 3'd4, 8'h07, 8'h55);
        // R1: reset restores configuration value
        drive(0, 0, 8'h00, 0, 0, 1, 8'h00);
        @(negedge clk);
        drive(0, 0, 8'h00, 0, 0, 0, 8'h00);
        chk("cfg1 write", 1, cfg1, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_all(1, 0, 8'h00, 8'h00, 3'd0, 8'h07, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule